// File: doc/BRIEF.md
# Synthesizer Lock Detect Timer

This block turns a raw phase-lock level from a synthesizer loop into a clean, registered lock flag. It counts reference-clock cycles during which the raw indication stays high. It raises the flag only once that run reaches a programmable window length. A 2-bit window code selects the length, and the length doubles with each code step. The flag can feed a status register or drive a status pin directly.

A 2-bit mode field selects the behaviour. Two codes turn detection off. Single-shot mode evaluates once after each enable and then holds its verdict. Continuous mode re-qualifies the lock at every cycle. Dropping the synthesizer enable clears all progress, so each enable starts a fresh evaluation.

Top module: `lkd_lock_timer`

## Requirements
- R1: After reset, lock_o is 0 and the run counter is empty.
- R2: With window code c, the window is 256·2^c reference cycles (code 0 = 256, 1 = 512, 2 = 1024, 3 = 2048). When raw_lock_i is sampled high on that many consecutive rising edges while evaluation runs, lock_o is 1 right after the edge that takes the last sample.
- R3: A low sample of raw_lock_i before the window is complete restarts the count from zero. A full new window of high samples is then needed.
- R4: In continuous mode (lock_mode_i = 2), a low sample of raw_lock_i clears lock_o at that edge. A new full window is needed before lock_o returns to 1.
- R5: In single-shot mode (lock_mode_i = 1), once lock_o is 1 it stays 1 whatever raw_lock_i does, as long as synth_en_i stays 1 and the mode is unchanged.
- R6: Mode 0 (off) and mode 3 (reserved, treated as off) hold lock_o at 0 and keep the counter empty. Switching into either mode clears a set lock_o at the next edge.
- R7: synth_en_i sampled low clears the counter and lock_o at that edge. After re-enable, a fresh full window is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| synth_en_i | input | 1 | Synthesizer enable |
| raw_lock_i | input | 1 | Raw phase-lock level from the loop |
| win_code_i | input | CODE_W (2) | Window length code |
| lock_mode_i | input | 2 | 0 off, 1 single-shot, 2 continuous, 3 reserved (off) |
| lock_o | output | 1 | Registered lock flag |

## Verification
A steady high raw level is applied under each of the four window codes. This shows that the flag rises on exactly the last edge of the selected window and not one edge early. A run broken by a single low cycle just short of the window separates a counter that restarts from one that only pauses. A single-cycle dropout after lock is applied in both continuous and single-shot mode, which tells the clearing behaviour apart from the holding behaviour. The enable is toggled and the off and reserved modes are applied under a long high raw level, which shows that neither leaves a stale lock or counter content behind.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

    typedef enum logic [1:0] {
        LKD_OFF  = 2'd0,
        LKD_ONCE = 2'd1,
        LKD_CONT = 2'd2,
        LKD_RSVD = 2'd3
    } lkd_mode_e;

endpackage

// File: rtl/lkd_window_sel.sv
module lkd_window_sel #(
    parameter int BASE_WIN = 256,
    parameter int CODE_W   = 2,
    parameter int CNT_W    = 12
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  limit_o
);
    localparam int NUM_CODES = 2 ** CODE_W;

    logic [CNT_W-1:0] win_tbl [NUM_CODES];

    // each code step doubles the window
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_win
        assign win_tbl[g] = CNT_W'(BASE_WIN * (2 ** g));
    end

    assign limit_o = win_tbl[code_i];
endmodule

// File: rtl/lkd_mode_ctrl.sv
module lkd_mode_ctrl
    import lkd_pkg::*;
(
    input  logic      en_i,
    input  lkd_mode_e mode_i,
    output logic      run_o,
    output logic      sticky_o
);
    always_comb begin
        run_o    = 1'b0;
        sticky_o = 1'b0;
        unique case (mode_i)
            LKD_ONCE: begin
                run_o    = en_i;
                sticky_o = 1'b1;
            end
            LKD_CONT: run_o = en_i;
            default:  run_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/lkd_core.sv
module lkd_core #(
    parameter int CNT_W   = 12,
    parameter int MAX_CNT = 2048
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             sticky_i,
    input  logic             raw_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             lock_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lock;
    } st_t;

    st_t          s_d, s_q;
    logic [CNT_W:0] inc_d;

    assign inc_d = {1'b0, s_q.cnt} + 1'b1;

    always_comb begin
        s_d = s_q;
        if (!run_i) begin
            s_d = '0;
        end else if (sticky_i && s_q.lock) begin
            s_d = s_q;
        end else if (raw_i) begin
            if (inc_d >= {1'b0, limit_i}) begin
                s_d.cnt  = limit_i;
                s_d.lock = 1'b1;
            end else begin
                s_d.cnt = inc_d[CNT_W-1:0];
            end
        end else begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign lock_o = s_q.lock;

    // R6 R7
    stop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (!lock_o && s_q.cnt == '0));

    // R5
    once_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && sticky_i && lock_o) |=> lock_o);

    // R4
    cont_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !sticky_i && !raw_i) |=> !lock_o);

    // R3
    rise_needs_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lock_o) |-> ($past(raw_i) && $past(run_i)));

    // R2
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt <= CNT_W'(MAX_CNT));
endmodule

// File: rtl/lkd_lock_timer.sv
module lkd_lock_timer
    import lkd_pkg::*;
#(
    parameter int BASE_WIN = 256,
    parameter int CODE_W   = 2
) (
    input  logic              clk_ref_i,
    input  logic              rst_ni,
    input  logic              synth_en_i,
    input  logic              raw_lock_i,
    input  logic [CODE_W-1:0] win_code_i,
    input  logic [1:0]        lock_mode_i,
    output logic              lock_o
);
    localparam int MAX_WIN = BASE_WIN * (2 ** ((2 ** CODE_W) - 1));
    localparam int CNT_W   = $clog2(MAX_WIN + 1);

    logic [CNT_W-1:0] limit;
    logic             run;
    logic             sticky;
    lkd_mode_e        mode;

    assign mode = lkd_mode_e'(lock_mode_i);

    lkd_window_sel #(
        .BASE_WIN (BASE_WIN),
        .CODE_W   (CODE_W),
        .CNT_W    (CNT_W)
    ) u_win (
        .code_i  (win_code_i),
        .limit_o (limit)
    );

    lkd_mode_ctrl u_mode (
        .en_i     (synth_en_i),
        .mode_i   (mode),
        .run_o    (run),
        .sticky_o (sticky)
    );

    lkd_core #(
        .CNT_W   (CNT_W),
        .MAX_CNT (MAX_WIN)
    ) u_core (
        .clk_i    (clk_ref_i),
        .rst_ni   (rst_ni),
        .run_i    (run),
        .sticky_i (sticky),
        .raw_i    (raw_lock_i),
        .limit_i  (limit),
        .lock_o   (lock_o)
    );

    // R6
    off_mode_chk: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
        (lock_mode_i == 2'd0 || lock_mode_i == 2'd3) |=> !lock_o);

    // R7
    en_low_chk: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
        !synth_en_i |=> !lock_o);
endmodule

// File: tb/lkd_lock_timer_tb.sv
module lkd_lock_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       raw = 1'b0;
    logic [1:0] code = 2'd0;
    logic [1:0] mode = 2'd0;
    logic       lock;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    int m_cnt = 0;
    bit m_lock = 1'b0;

    always #10 clk = ~clk;

    lkd_lock_timer u_dut (
        .clk_ref_i   (clk),
        .rst_ni      (rst_n),
        .synth_en_i  (en),
        .raw_lock_i  (raw),
        .win_code_i  (code),
        .lock_mode_i (mode),
        .lock_o      (lock)
    );

    // expected flag after the next rising edge, from the requirements
    task automatic step(input bit e, input bit r, input bit [1:0] md,
                        input bit [1:0] cd, input string tag);
        int lim;
        bit act;
        @(negedge clk);
        en = e; raw = r; mode = md; code = cd;
        lim = 256 << cd;
        act = e && (md == 2'd1 || md == 2'd2);
        if (!act) begin
            m_cnt = 0; m_lock = 1'b0;
        end else if (md == 2'd1 && m_lock) begin
            m_lock = 1'b1;
        end else if (r) begin
            m_cnt = m_cnt + 1;
            if (m_cnt >= lim) begin
                m_cnt = lim; m_lock = 1'b1;
            end
        end else begin
            m_cnt = 0; m_lock = 1'b0;
        end
        exp_q.push_back(m_lock);
        tag_q.push_back(tag);
    endtask

    task automatic run(input int n, input bit e, input bit r,
                       input bit [1:0] md, input bit [1:0] cd, input string tag);
        for (int i = 0; i < n; i++) step(e, r, md, cd, tag);
    endtask

    // monitor: compare each expected item a quarter period after its edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (lock !== e) begin
                    errors++;
                    $display("FAIL %s: lock_o=%0b expected=%0b at %0t", t, lock, e, $time);
                end
            end
        end
    end

    initial begin
        #(100000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (lock !== 1'b0) begin
            errors++;
            $display("FAIL R1: lock_o=%0b expected=0", lock);
        end
        rst_n = 1'b1;
        run(2, 1'b0, 1'b0, 2'd0, 2'd0, "R1");

        // R2 each window code, continuous mode, steady high
        for (int c = 0; c < 4; c++) begin
            run((256 << c) + 4, 1'b1, 1'b1, 2'd2, 2'(c), "R2");
            run(2, 1'b0, 1'b1, 2'd2, 2'(c), "R7");
        end

        // R3 break one cycle short of the window
        run(255, 1'b1, 1'b1, 2'd2, 2'd0, "R3");
        run(1, 1'b1, 1'b0, 2'd2, 2'd0, "R3");
        run(258, 1'b1, 1'b1, 2'd2, 2'd0, "R3");

        // R4 dropout after lock in continuous mode
        run(1, 1'b1, 1'b0, 2'd2, 2'd0, "R4");
        run(20, 1'b1, 1'b1, 2'd2, 2'd0, "R4");
        run(2, 1'b0, 1'b0, 2'd2, 2'd0, "R7");

        // R5 single-shot holds through dropouts
        run(257, 1'b1, 1'b1, 2'd1, 2'd0, "R5");
        run(20, 1'b1, 1'b0, 2'd1, 2'd0, "R5");
        for (int i = 0; i < 10; i++) step(1'b1, 1'(i % 2), 2'd1, 2'd0, "R5");

        // R7 enable drop clears, re-enable needs a fresh window
        run(1, 1'b0, 1'b1, 2'd1, 2'd0, "R7");
        run(100, 1'b1, 1'b1, 2'd1, 2'd0, "R7");
        run(1, 1'b0, 1'b1, 2'd1, 2'd0, "R7");

        // R6 off and reserved modes
        run(300, 1'b1, 1'b1, 2'd0, 2'd0, "R6");
        run(300, 1'b1, 1'b1, 2'd3, 2'd0, "R6");
        run(257, 1'b1, 1'b1, 2'd2, 2'd0, "R6");
        run(3, 1'b1, 1'b1, 2'd3, 2'd0, "R6");
        run(257, 1'b1, 1'b1, 2'd1, 2'd0, "R6");
        run(3, 1'b1, 1'b1, 2'd0, 2'd0, "R6");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule